// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel for a peripheral subsystem. A down-counter advances on an external tick enable, optionally divided by 16 or 256 through a prescaler. The channel raises a level interrupt each time the count reaches zero. Software drives it through a synchronous register port: a word index, a write strobe, a read strobe and 32-bit data. Reads are combinational and return zero whenever the read strobe is low.

Three counting modes are offered, each at a 16-bit or 32-bit width. Periodic mode reloads from a programmed value. Free-running mode wraps from the all-ones value of the selected width. One-shot mode stops at zero after its first expiry. The reload value can be written in two ways: one forces the count at once, and the other only takes effect at the next natural reload. The interrupt status is readable both raw and masked by the enable bit.

Top module: `dctimer_chan`

## Requirements
- R1: After reset, the control register (index 2) reads 0x20, the count (index 1), the reload value (index 0) and raw status (index 4) read 0, and `irq` is low.
- R2: A write to index 0 stores the reload value and sets the count to it on the same edge; indices 0 and 6 both read back the stored reload value.
- R3: A write to index 6 stores the reload value without changing the running count; the new value is used at the next reload after zero.
- R4: Control bits 3:2 select the prescaler: 00 decrements once per tick, 01 once per 16 ticks, 10 once per 256 ticks, 11 behaves as 00; any control write restarts the prescaler, and clock edges without `tick_en` do not advance it.
- R5: When enabled, the count decrements by one per prescaled tick; the step from 1 to 0 sets the raw flag, and in periodic mode (bit 6 set, bit 0 clear) the next step reloads the stored value.
- R6: With bits 0 and 6 both clear, the counter is free-running and reloads from 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode (bit 1 set); enabling it by a control write also starts it from that value.
- R7: With bit 0 set (one-shot), the count stays at zero after its expiry until index 0 is written or the control register is written with bit 7 set.
- R8: With bit 1 clear, only the low 16 bits of the count decrement and wrap, and index 1 reads them zero-extended.
- R9: Any write to index 3 clears the raw flag; an expiry on the same edge leaves it set.
- R10: Index 5 reads the raw flag when bit 5 (interrupt enable) is set and 0 otherwise, and `irq` equals that same value.
- R11: Writes to index 1 are ignored; reads of index 7 return 0, and `rdata` is 0 while `rd_en` is low.
- R12: A control write with bit 7 set reloads the count from the reload source of the new mode; with bit 7 clear the count does not change. Bit 4 and bits above 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-rate enable, one pulse per input tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (3) | Register word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
On every cycle, the embedded properties check several behaviours. They check that a forced load appears in the count on the next edge, and that a background write leaves the count untouched. They check that each prescaled step lowers the count by exactly one, and that a free-running wrap lands on the width's all-ones value. They also check that a halted one-shot or a disabled channel keeps its count, that a clear empties the raw flag unless an expiry coincides, and that a divided prescaler never steps twice in a row. Other behaviours need the bench's scenarios. These include the exact tick spacing of the 16 and 256 dividers, the delayed effect of a background write at the next reload, and the masked status and interrupt pin following the enable bit. They also include the reset values and the register readback paths.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;

   // Register word indices; software decodes these positions.
   typedef enum logic [2:0] {
      REG_RELOAD = 3'd0,
      REG_COUNT  = 3'd1,
      REG_MODE   = 3'd2,
      REG_ACK    = 3'd3,
      REG_RAW    = 3'd4,
      REG_MASKED = 3'd5,
      REG_SHADOW = 3'd6
   } reg_idx_e;

   // Control byte, bit 7 down to bit 0.
   typedef struct packed {
      logic       run;       // bit 7
      logic       periodic;  // bit 6
      logic       int_en;    // bit 5
      logic       spare;     // bit 4, reads zero
      logic [1:0] div_sel;   // bits 3:2
      logic       wide;      // bit 1
      logic       single;    // bit 0
   } mode_t;

   localparam mode_t MODE_RESET = 8'h20;
   localparam int    MODE_W     = 8;

endpackage

// File: rtl/dctimer_prescale.sv
module dctimer_prescale #(
   parameter int SHIFT_A = 4,
   parameter int SHIFT_B = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       step
);
   localparam int PW = SHIFT_B;

   generate
      if (SHIFT_A < 1 || SHIFT_A >= SHIFT_B) begin : g_bad_shift
         $error("dctimer_prescale: SHIFT_A must be in 1..SHIFT_B-1");
      end
   endgenerate

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;
   logic          at_limit;

   always_comb begin
      unique case (sel)
         2'b01:   limit = PW'((1 << SHIFT_A) - 1);
         2'b10:   limit = {PW{1'b1}};
         default: limit = '0;
      endcase
   end

   assign at_limit = (pcnt_q >= limit);
   assign step     = run && tick && !restart && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (restart || !run) begin
         pcnt_q <= '0;
      end else if (tick) begin
         pcnt_q <= at_limit ? '0 : pcnt_q + PW'(1);
      end
   end

   AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && limit != '0 && !restart) |=> !step); // R4

endmodule

// File: rtl/dctimer_flag.sv
module dctimer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic raw
);
   always_ff @(posedge clk) begin
      if (!rst_n)   raw <= 1'b0;
      else if (set) raw <= 1'b1;
      else if (clr) raw <= 1'b0;
   end

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !raw); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> raw); // R5

endmodule

// File: rtl/dctimer_count.sv
module dctimer_count #(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wide,
   input  logic              single,
   input  logic              jam,
   input  logic [DATA_W-1:0] jam_val,
   input  logic [DATA_W-1:0] reload_val,
   output logic [DATA_W-1:0] view,
   output logic              expire
);
   localparam logic [DATA_W-1:0] NMASK = {DATA_W{1'b1}} >> (DATA_W - NARROW_W);

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] eff;
   logic [DATA_W-1:0] dec;

   generate
      if (NARROW_W == DATA_W) begin : g_full
         logic unused_wide;
         assign unused_wide = wide;
         assign eff = cnt_q;
         assign dec = cnt_q - DATA_W'(1);
      end else begin : g_split
         assign eff = wide ? cnt_q : (cnt_q & NMASK);
         assign dec = wide ? (cnt_q - DATA_W'(1))
                           : ((cnt_q & ~NMASK) | ((cnt_q - DATA_W'(1)) & NMASK));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (jam) begin
         cnt_q <= jam_val;
      end else if (step) begin
         if (eff == '0) begin
            if (!single) cnt_q <= reload_val;
         end else begin
            cnt_q <= dec;
         end
      end
   end

   assign view   = eff;
   assign expire = step && !jam && (eff == DATA_W'(1));

endmodule

// File: rtl/dctimer_chan.sv
module dctimer_chan
   import dctimer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NARROW_W  = 16,
   parameter int ADDR_W    = 3,
   parameter int PRE_A_LOG = 4,
   parameter int PRE_B_LOG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam logic [DATA_W-1:0] NMASK = {DATA_W{1'b1}} >> (DATA_W - NARROW_W);
   localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};

   generate
      if (DATA_W < MODE_W || NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_width
         $error("dctimer_chan: need 8 <= DATA_W and 1 <= NARROW_W <= DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("dctimer_chan: ADDR_W must be at least 3");
      end
   endgenerate

   mode_t             mode_q;
   mode_t             mode_new;
   logic [DATA_W-1:0] reload_q;
   logic              wr_reload, wr_mode, wr_ack, wr_shadow;
   logic              jam;
   logic [DATA_W-1:0] jam_val;
   logic              step;
   logic              expire;
   logic              raw;
   logic [DATA_W-1:0] cnt_view;

   function automatic logic [DATA_W-1:0] reload_src(mode_t m, logic [DATA_W-1:0] ld);
      if (!m.periodic && !m.single) return m.wide ? ONES : NMASK;
      return m.wide ? ld : (ld & NMASK);
   endfunction

   assign wr_reload = wr_en && (addr == ADDR_W'(REG_RELOAD));
   assign wr_mode   = wr_en && (addr == ADDR_W'(REG_MODE));
   assign wr_ack    = wr_en && (addr == ADDR_W'(REG_ACK));
   assign wr_shadow = wr_en && (addr == ADDR_W'(REG_SHADOW));

   always_comb begin
      mode_new       = mode_t'(wdata[MODE_W-1:0]);
      mode_new.spare = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_RESET;
         reload_q <= '0;
      end else begin
         if (wr_mode)                reload_q <= reload_q;
         if (wr_reload || wr_shadow) reload_q <= wdata;
         if (wr_mode)                mode_q   <= mode_new;
      end
   end

   assign jam     = wr_reload || (wr_mode && mode_new.run);
   assign jam_val = wr_reload ? wdata : reload_src(mode_new, reload_q);

   dctimer_prescale #(
      .SHIFT_A (PRE_A_LOG),
      .SHIFT_B (PRE_B_LOG)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (mode_q.run),
      .tick    (tick_en),
      .restart (wr_mode),
      .sel     (mode_q.div_sel),
      .step    (step)
   );

   dctimer_count #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .wide       (mode_q.wide),
      .single     (mode_q.single),
      .jam        (jam),
      .jam_val    (jam_val),
      .reload_val (reload_src(mode_q, reload_q)),
      .view       (cnt_view),
      .expire     (expire)
   );

   dctimer_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .clr   (wr_ack),
      .raw   (raw)
   );

   assign irq = raw && mode_q.int_en;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_W'(REG_RELOAD), ADDR_W'(REG_SHADOW): rdata = reload_q;
            ADDR_W'(REG_COUNT):  rdata = cnt_view;
            ADDR_W'(REG_MODE):   rdata = DATA_W'(mode_q);
            ADDR_W'(REG_RAW):    rdata = DATA_W'(raw);
            ADDR_W'(REG_MASKED): rdata = DATA_W'(raw && mode_q.int_en);
            default:             rdata = '0;
         endcase
      end
   end

   AST_LOAD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> cnt_view == (mode_q.wide ? $past(wdata) : ($past(wdata) & NMASK))); // R2
   AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_shadow && !step) |=> $stable(cnt_view)); // R3
   AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_view > DATA_W'(1) && !wr_en) |=> cnt_view == $past(cnt_view) - DATA_W'(1)); // R5
   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_view == '0 && !mode_q.periodic && !mode_q.single && !wr_en)
      |=> cnt_view == (mode_q.wide ? ONES : NMASK)); // R6
   AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.run && mode_q.single && cnt_view == '0 && !wr_en) |=> cnt_view == '0); // R7
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.run && !wr_en) |=> $stable(cnt_view)); // R12

endmodule

// File: tb/dctimer_chan_bench.sv
module dctimer_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dctimer_chan u_dctimer_chan (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // row: {is_read, index, write data, expected read, requirement number}
   localparam int NV = 22;
   localparam logic [75:0] VECS [NV] = '{
      {1'b1, 3'd2, 32'h0,      32'h20,   8'd1},  // R1 control reset
      {1'b1, 3'd1, 32'h0,      32'h0,    8'd1},  // R1 count reset
      {1'b1, 3'd4, 32'h0,      32'h0,    8'd1},  // R1 raw reset
      {1'b1, 3'd0, 32'h0,      32'h0,    8'd1},  // R1 reload reset
      {1'b0, 3'd0, 32'h1234,   32'h0,    8'd2},
      {1'b1, 3'd1, 32'h0,      32'h1234, 8'd2},  // R2 count forced
      {1'b1, 3'd0, 32'h0,      32'h1234, 8'd2},  // R2 reload readback
      {1'b1, 3'd6, 32'h0,      32'h1234, 8'd2},  // R2 shadow readback
      {1'b0, 3'd6, 32'h55,     32'h0,    8'd3},
      {1'b1, 3'd1, 32'h0,      32'h1234, 8'd3},  // R3 count untouched
      {1'b1, 3'd6, 32'h0,      32'h55,   8'd3},  // R3 value stored
      {1'b1, 3'd0, 32'h0,      32'h55,   8'd3},  // R3 value stored
      {1'b0, 3'd1, 32'hDEAD,   32'h0,    8'd11},
      {1'b1, 3'd1, 32'h0,      32'h1234, 8'd11}, // R11 write ignored
      {1'b1, 3'd7, 32'h0,      32'h0,    8'd11}, // R11 unmapped read
      {1'b0, 3'd2, 32'hFF7F,   32'h0,    8'd12},
      {1'b1, 3'd2, 32'h0,      32'h6F,   8'd12}, // R12 bit 4 and upper read zero
      {1'b1, 3'd1, 32'h0,      32'h1234, 8'd12}, // R12 disabled write keeps count
      {1'b0, 3'd2, 32'h22,     32'h0,    8'd12},
      {1'b1, 3'd5, 32'h0,      32'h0,    8'd10}, // R10 masked status idle
      {1'b0, 3'd0, 32'h3,      32'h0,    8'd2},
      {1'b1, 3'd1, 32'h0,      32'h3,    8'd2}   // R2 count forced
   };

   task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                      input string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = idx; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] v);
      rd_en = 1'b1; addr = idx;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic expect_reg(input int req, input logic [2:0] idx, input logic [31:0] exp,
                             input string what);
      logic [31:0] v;
      rd(idx, v);
      chk(req, v, exp, what);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk(1, 32'(irq), 0, "irq low after reset"); // R1
      v = rdata;
      chk(11, v, 0, "rdata zero without rd_en"); // R11

      for (int i = 0; i < NV; i++) begin
         if (VECS[i][75]) expect_reg(int'(VECS[i][7:0]), VECS[i][74:72], VECS[i][39:8], "table read");
         else             wr(VECS[i][74:72], VECS[i][71:40]);
      end

      tick_en = 1'b1;
      // R12 enable reloads, R5 periodic countdown
      wr(2, 32'hE2);
      expect_reg(12, 1, 3, "enable reload");
      edges(1); expect_reg(5, 1, 2, "decrement");
      edges(1); expect_reg(5, 1, 1, "decrement"); expect_reg(5, 4, 0, "raw before expiry");
      edges(1); expect_reg(5, 1, 0, "at zero"); expect_reg(5, 4, 1, "raw at expiry");
      expect_reg(10, 5, 1, "masked with enable"); chk(10, 32'(irq), 1, "irq with enable");
      edges(1); expect_reg(5, 1, 3, "periodic reload");
      // R9 clear
      wr(3, 0); expect_reg(9, 4, 0, "cleared");
      // R10 masked off
      wr(2, 32'hC2); edges(3);
      expect_reg(5, 1, 0, "expired again");
      expect_reg(10, 4, 1, "raw set, ie off"); expect_reg(10, 5, 0, "masked off");
      chk(10, 32'(irq), 0, "irq masked off");
      // R9 collision of clear and expiry
      wr(2, 32'hE2); wr(3, 0); expect_reg(9, 4, 0, "cleared");
      wr(0, 1); wr(3, 0); expect_reg(9, 4, 1, "expiry beats clear");
      // R3 shadow applies at next reload
      wr(0, 2); expect_reg(2, 1, 2, "forced");
      wr(6, 5); expect_reg(3, 1, 1, "shadow keeps count");
      edges(1); expect_reg(3, 1, 0, "zero");
      edges(1); expect_reg(3, 1, 5, "reload uses shadow value");
      // R7 one-shot
      wr(3, 0); wr(2, 32'hA3); expect_reg(7, 1, 5, "one-shot start");
      edges(5); expect_reg(7, 1, 0, "one-shot zero"); expect_reg(7, 4, 1, "one-shot raw");
      edges(3); expect_reg(7, 1, 0, "one-shot halted");
      wr(0, 2); expect_reg(7, 1, 2, "one-shot restart by load");
      // R12 disabled count frozen
      wr(2, 32'h22); edges(3); expect_reg(12, 1, 2, "disabled frozen");
      // R8 narrow width, R6 free-running
      wr(0, 32'h0001_0002); expect_reg(2, 1, 32'h0001_0002, "wide load");
      wr(2, 32'h20); expect_reg(8, 1, 2, "narrow view");
      wr(2, 32'hA0); expect_reg(6, 1, 32'hFFFF, "narrow free start");
      wr(0, 32'h0005_0002); expect_reg(8, 1, 2, "narrow view of load");
      edges(1); expect_reg(8, 1, 1, "narrow decrement");
      edges(1); expect_reg(8, 1, 0, "narrow zero");
      edges(1); expect_reg(6, 1, 32'hFFFF, "narrow free wrap");
      wr(2, 32'hA2); expect_reg(6, 1, 32'hFFFF_FFFF, "wide free start");
      edges(1); expect_reg(6, 1, 32'hFFFF_FFFE, "wide free decrement");
      // R4 prescaler
      wr(0, 100);
      wr(2, 32'hE6); edges(15); expect_reg(4, 1, 100, "div16 before");
      edges(1); expect_reg(4, 1, 99, "div16 step");
      wr(2, 32'hEA); edges(255); expect_reg(4, 1, 100, "div256 before");
      edges(1); expect_reg(4, 1, 99, "div256 step");
      wr(2, 32'hEE); edges(1); expect_reg(4, 1, 99, "sel 11 undivided");
      tick_en = 1'b0; edges(3); expect_reg(4, 1, 99, "no tick no step");
      tick_en = 1'b1; edges(1); expect_reg(4, 1, 98, "tick resumes");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule